// File: doc/BRIEF.md
# DMA Request Descriptor Sequencer

This block takes one fetched DMA request descriptor and carries it through to completion in a fixed order. First it clears an optional gating semaphore. Then it issues the data transfer, if the descriptor asks for one. Then it hands the remaining semaphore operations to the semaphore unit, one at a time, and waits for each grant. Last, it writes an optional doorbell, which can be 8, 16 or 32 bits wide. When all of this is done it can emit a response element that carries the request ID and a completion code. It does not move data, walk linked lists or manage ring pointers. Each of those tasks belongs to a neighbouring unit, reached through a handshaked port.

All flowing traffic uses valid/ready handshakes. These are the descriptor input, the semaphore, DMA and doorbell request outputs, and the response output. A valid output holds its payload unchanged until the matching ready is seen at a clock edge. The consumer may keep ready low for any number of cycles, and the sequencer then waits in that phase. Only one descriptor is in flight at a time. The sequencer takes a new descriptor only when it is idle, so back-pressure on any output stalls the descriptor input as well.

Before any phase starts, the sequencer checks the descriptor for malformed content. A bad descriptor skips every phase and is reported through the completion code. A transfer that fails is reported the same way.

Top module: `desc_sequencer`

## Requirements
- R1: `desc_ready` is high only while the sequencer is idle. A descriptor is taken on `desc_valid && desc_ready`. The sequence byte `desc_seq` is forwarded unchanged on `dma_seq` and has no other effect.
- R2: Phases run strictly in this order: presync semaphore, DMA, postsync semaphores, doorbell, response. At most one of `sem_valid`, `dma_valid`, `db_valid` and `rsp_valid` is high in any cycle.
- R3: Command bits [1:0] set the transfer: 0 issues no DMA, 1 issues `dma_dir`=1 (to device) and 2 issues `dma_dir`=2 (from device). Command bit 3 appears on `dma_bulk` (1 = bulk, 0 = linked list). Source, destination and 32-bit length pass through unchanged.
- R4: Each 32-bit semaphore word uses bit 31 as enable and bit 22 as presync. The one enabled presync word is issued on `sem_cmd` before the DMA. Enabled words with bit 22 clear are issued after the DMA, lowest index first. Words with bit 31 clear are never issued.
- R5: Doorbell attribute bit 7 enables the doorbell write. Attribute bits [1:0] appear on `db_size`, where 0 means 32-bit, 1 means 16-bit and 2 means 8-bit. `db_data` carries only the low 32, 16 or 8 data bits, and the upper bits are zero. With bit 7 clear, no doorbell is issued and the length and alignment are not checked.
- R6: With command bit 4 set, exactly one response is sent, carrying `rsp_id` equal to the descriptor ID and `rsp_code` equal to 0 on success. With bit 4 clear, no response is sent.
- R7: A malformed descriptor issues no semaphore, DMA or doorbell request. The checks run in this priority order, and the first one that matches sets the code:
  - transfer type 3 gives code 1;
  - more than one enabled presync word gives code 2;
  - an enabled doorbell with length code 3 gives code 3;
  - an enabled doorbell whose address is not aligned to its length gives code 4.
- R8: A DMA completion with `dma_fail` high skips the postsync and doorbell phases and gives code 5.
- R9: With command bit 7 set, `irq_force` pulses for one cycle when the descriptor retires. If a response is sent, that is the cycle of the response handshake.
- R10: While an output's valid is high and its ready is low, that valid stays high and its payload stays stable.
- R11: After reset, `desc_ready` is high and all request and response valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Sequencer idle, descriptor taken |
| desc_id | input | 16 | Request ID |
| desc_seq | input | 8 | Sequence byte, passed through |
| desc_cmd | input | 8 | Command byte |
| desc_src | input | 64 | Transfer source address |
| desc_dst | input | 64 | Transfer destination address |
| desc_len | input | 32 | Transfer length |
| desc_db_addr | input | 64 | Doorbell address |
| desc_db_attr | input | 8 | Doorbell attribute byte |
| desc_db_data | input | 32 | Doorbell data |
| desc_sem | input | 128 | Four semaphore words, word 0 in the low bits |
| sem_valid | output | 1 | Semaphore command offered |
| sem_ready | input | 1 | Semaphore granted |
| sem_cmd | output | 32 | Semaphore command word |
| dma_valid | output | 1 | DMA command offered |
| dma_ready | input | 1 | DMA command taken |
| dma_dir | output | 2 | Transfer direction |
| dma_bulk | output | 1 | Bulk (1) or linked list (0) |
| dma_seq | output | 8 | Forwarded sequence byte |
| dma_src | output | 64 | Source address |
| dma_dst | output | 64 | Destination address |
| dma_len | output | 32 | Transfer length |
| dma_done | input | 1 | Transfer finished pulse |
| dma_fail | input | 1 | Transfer failed, valid with dma_done |
| db_valid | output | 1 | Doorbell write offered |
| db_ready | input | 1 | Doorbell write taken |
| db_addr | output | 64 | Doorbell address |
| db_size | output | 2 | Doorbell length code |
| db_data | output | 32 | Masked doorbell data |
| rsp_valid | output | 1 | Response element offered |
| rsp_ready | input | 1 | Response element taken |
| rsp_id | output | 16 | Request ID of the response |
| rsp_code | output | 16 | Completion code |
| irq_force | output | 1 | Forced interrupt pulse on retire |

## Verification
Two events can fall in the same cycle: the response handshake and the forced-interrupt pulse. Separately, a new descriptor may be waiting at the input while the response is still held off. The bench sends a descriptor with bits 7 and 4 set and keeps `rsp_ready` high. It records the cycle of every handshake and pulse and requires the `irq_force` pulse to fall in exactly the cycle of the response handshake. In a second run it holds `rsp_ready` low for several cycles. During that time it requires `rsp_valid` to stay high with a stable ID and `desc_ready` to stay low, so that no second descriptor can slip in before the response is taken.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DMA_REQ,
    ST_DMA_WAIT,
    ST_POST,
    ST_DB,
    ST_FIN
  } seq_state_t;

  localparam int unsigned SEM_W       = 32;
  localparam int unsigned SEM_EN_BIT  = 31;
  localparam int unsigned SEM_PRE_BIT = 22;

  localparam int unsigned CMD_BULK_BIT = 3;
  localparam int unsigned CMD_RSP_BIT  = 4;
  localparam int unsigned CMD_IRQ_BIT  = 7;
  localparam int unsigned DB_EN_BIT    = 7;

  localparam logic [1:0] XFER_NONE = 2'd0;
  localparam logic [1:0] XFER_BAD  = 2'd3;

  localparam logic [1:0] DBLEN_32  = 2'd0;
  localparam logic [1:0] DBLEN_16  = 2'd1;
  localparam logic [1:0] DBLEN_8   = 2'd2;

  localparam logic [15:0] CC_OK        = 16'd0;
  localparam logic [15:0] CC_BAD_XFER  = 16'd1;
  localparam logic [15:0] CC_MULTI_PRE = 16'd2;
  localparam logic [15:0] CC_DB_LEN    = 16'd3;
  localparam logic [15:0] CC_DB_ALIGN  = 16'd4;
  localparam logic [15:0] CC_DMA_FAIL  = 16'd5;
endpackage

// File: rtl/dsq_decode.sv
module dsq_decode
  import dsq_pkg::*;
#(
  parameter int unsigned N_SEM = 4
) (
  input  logic [7:0]             cmd,
  input  logic [7:0]             db_attr,
  input  logic [1:0]             db_addr_lo,
  input  logic [N_SEM*SEM_W-1:0] sem_words,
  output logic [15:0]            err_code,
  output logic [N_SEM-1:0]       pre_mask,
  output logic [N_SEM-1:0]       post_mask
);
  localparam int unsigned CW = $clog2(N_SEM + 1);

  for (genvar g = 0; g < N_SEM; g++) begin : g_word
    logic en, pre;
    assign en           = sem_words[g*SEM_W + SEM_EN_BIT];
    assign pre          = sem_words[g*SEM_W + SEM_PRE_BIT];
    assign pre_mask[g]  = en & pre;
    assign post_mask[g] = en & ~pre;
  end

  logic [CW-1:0] pre_cnt;
  always_comb begin
    pre_cnt = '0;
    for (int i = 0; i < N_SEM; i++) pre_cnt = pre_cnt + CW'(pre_mask[i]);
  end

  logic db_en, db_misaligned;
  assign db_en = db_attr[DB_EN_BIT];
  assign db_misaligned = ((db_attr[1:0] == DBLEN_32) && (db_addr_lo != 2'b00)) ||
                         ((db_attr[1:0] == DBLEN_16) && db_addr_lo[0]);

  always_comb begin
    if (cmd[1:0] == XFER_BAD)                    err_code = CC_BAD_XFER;
    else if (pre_cnt > CW'(1))                   err_code = CC_MULTI_PRE;
    else if (db_en && (db_attr[1:0] == 2'd3))    err_code = CC_DB_LEN;
    else if (db_en && db_misaligned)             err_code = CC_DB_ALIGN;
    else                                         err_code = CC_OK;
  end

  logic unused_bits;
  assign unused_bits = ^{sem_words, cmd[7:2], db_attr[6:2]};
endmodule

// File: rtl/dsq_pick.sv
module dsq_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/dsq_db_fmt.sv
module dsq_db_fmt
  import dsq_pkg::*;
#(
  parameter int unsigned DB_W = 32
) (
  input  logic [1:0]      len_code,
  input  logic [DB_W-1:0] data_in,
  output logic [DB_W-1:0] data_out
);
  localparam logic [DB_W-1:0] MASK16 = {{(DB_W-16){1'b0}}, {16{1'b1}}};
  localparam logic [DB_W-1:0] MASK8  = {{(DB_W-8){1'b0}}, {8{1'b1}}};

  logic [DB_W-1:0] mask;
  always_comb begin
    case (len_code)
      DBLEN_16: mask = MASK16;
      DBLEN_8:  mask = MASK8;
      default:  mask = '1;
    endcase
  end
  assign data_out = data_in & mask;
endmodule

// File: rtl/desc_sequencer.sv
module desc_sequencer
  import dsq_pkg::*;
#(
  parameter int unsigned N_SEM = 4,
  parameter int unsigned AW    = 64,
  parameter int unsigned LW    = 32,
  parameter int unsigned IDW   = 16,
  parameter int unsigned DB_W  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   desc_valid,
  output logic                   desc_ready,
  input  logic [IDW-1:0]         desc_id,
  input  logic [7:0]             desc_seq,
  input  logic [7:0]             desc_cmd,
  input  logic [AW-1:0]          desc_src,
  input  logic [AW-1:0]          desc_dst,
  input  logic [LW-1:0]          desc_len,
  input  logic [AW-1:0]          desc_db_addr,
  input  logic [7:0]             desc_db_attr,
  input  logic [DB_W-1:0]        desc_db_data,
  input  logic [N_SEM*32-1:0]    desc_sem,
  output logic                   sem_valid,
  input  logic                   sem_ready,
  output logic [31:0]            sem_cmd,
  output logic                   dma_valid,
  input  logic                   dma_ready,
  output logic [1:0]             dma_dir,
  output logic                   dma_bulk,
  output logic [7:0]             dma_seq,
  output logic [AW-1:0]          dma_src,
  output logic [AW-1:0]          dma_dst,
  output logic [LW-1:0]          dma_len,
  input  logic                   dma_done,
  input  logic                   dma_fail,
  output logic                   db_valid,
  input  logic                   db_ready,
  output logic [AW-1:0]          db_addr,
  output logic [1:0]             db_size,
  output logic [DB_W-1:0]        db_data,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [IDW-1:0]         rsp_id,
  output logic [15:0]            rsp_code,
  output logic                   irq_force
);
  localparam int unsigned IW = (N_SEM > 1) ? $clog2(N_SEM) : 1;

  seq_state_t           st;
  logic [IDW-1:0]       r_id;
  logic [7:0]           r_seq, r_cmd, r_attr;
  logic [AW-1:0]        r_src, r_dst, r_db_addr;
  logic [LW-1:0]        r_len;
  logic [DB_W-1:0]      r_db_data;
  logic [N_SEM*32-1:0]  r_sem;
  logic [15:0]          r_code;
  logic [N_SEM-1:0]     r_post;
  logic [IW-1:0]        r_pre_idx;
  logic                 r_has_pre;

  logic [15:0]      dec_err;
  logic [N_SEM-1:0] dec_pre, dec_post;
  logic [IW-1:0]    dec_pre_idx, post_idx;
  logic             dec_has_pre, post_any;

  dsq_decode #(.N_SEM(N_SEM)) u_dec (
    .cmd(desc_cmd), .db_attr(desc_db_attr), .db_addr_lo(desc_db_addr[1:0]),
    .sem_words(desc_sem), .err_code(dec_err),
    .pre_mask(dec_pre), .post_mask(dec_post)
  );

  dsq_pick #(.N(N_SEM), .IW(IW)) u_pick_pre (
    .req(dec_pre), .idx(dec_pre_idx), .any(dec_has_pre)
  );

  dsq_pick #(.N(N_SEM), .IW(IW)) u_pick_post (
    .req(r_post), .idx(post_idx), .any(post_any)
  );

  dsq_db_fmt #(.DB_W(DB_W)) u_db (
    .len_code(r_attr[1:0]), .data_in(r_db_data), .data_out(db_data)
  );

  logic take, xfer_on, db_on, rsp_on, fin_leave;
  assign take      = desc_valid && desc_ready;
  assign xfer_on   = (r_cmd[1:0] != XFER_NONE);
  assign db_on     = r_attr[DB_EN_BIT];
  assign rsp_on    = r_cmd[CMD_RSP_BIT];
  assign fin_leave = (st == ST_FIN) && (!rsp_on || rsp_ready);

  assign desc_ready = (st == ST_IDLE);
  assign sem_valid  = ((st == ST_PRE) && r_has_pre) || ((st == ST_POST) && post_any);
  assign sem_cmd    = (st == ST_PRE) ? r_sem[r_pre_idx*32 +: 32] : r_sem[post_idx*32 +: 32];
  assign dma_valid  = (st == ST_DMA_REQ) && xfer_on;
  assign dma_dir    = r_cmd[1:0];
  assign dma_bulk   = r_cmd[CMD_BULK_BIT];
  assign dma_seq    = r_seq;
  assign dma_src    = r_src;
  assign dma_dst    = r_dst;
  assign dma_len    = r_len;
  assign db_valid   = (st == ST_DB) && db_on;
  assign db_addr    = r_db_addr;
  assign db_size    = r_attr[1:0];
  assign rsp_valid  = (st == ST_FIN) && rsp_on;
  assign rsp_id     = r_id;
  assign rsp_code   = r_code;
  assign irq_force  = fin_leave && r_cmd[CMD_IRQ_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      r_id      <= '0;
      r_seq     <= '0;
      r_cmd     <= '0;
      r_attr    <= '0;
      r_src     <= '0;
      r_dst     <= '0;
      r_db_addr <= '0;
      r_len     <= '0;
      r_db_data <= '0;
      r_sem     <= '0;
      r_code    <= CC_OK;
      r_post    <= '0;
      r_pre_idx <= '0;
      r_has_pre <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (take) begin
          r_id      <= desc_id;
          r_seq     <= desc_seq;
          r_cmd     <= desc_cmd;
          r_attr    <= desc_db_attr;
          r_src     <= desc_src;
          r_dst     <= desc_dst;
          r_db_addr <= desc_db_addr;
          r_len     <= desc_len;
          r_db_data <= desc_db_data;
          r_sem     <= desc_sem;
          r_code    <= dec_err;
          r_post    <= dec_post;
          r_pre_idx <= dec_pre_idx;
          r_has_pre <= dec_has_pre;
          st        <= (dec_err != CC_OK) ? ST_FIN : ST_PRE;
        end
        ST_PRE: if (!r_has_pre || sem_ready) st <= ST_DMA_REQ;
        ST_DMA_REQ: begin
          if (!xfer_on)       st <= ST_POST;
          else if (dma_ready) st <= ST_DMA_WAIT;
        end
        ST_DMA_WAIT: if (dma_done) begin
          if (dma_fail) begin
            r_code <= CC_DMA_FAIL;
            st     <= ST_FIN;
          end else begin
            st     <= ST_POST;
          end
        end
        ST_POST: begin
          if (!post_any) st <= ST_DB;
          else if (sem_ready) r_post[post_idx] <= 1'b0;
        end
        ST_DB: if (!db_on || db_ready) st <= ST_FIN;
        ST_FIN: if (fin_leave) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic unused_cmd;
  assign unused_cmd = ^{r_cmd[6:5], r_cmd[2], r_attr[6:2]};

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sem_valid, dma_valid, db_valid, rsp_valid})); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready |-> !(sem_valid || dma_valid || db_valid || rsp_valid)); // R1
  AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid && !dma_ready |=> dma_valid && $stable({dma_dir, dma_src, dma_dst, dma_len})); // R10
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable({rsp_id, rsp_code})); // R10
  AST_SEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sem_valid && !sem_ready |=> sem_valid && $stable(sem_cmd)); // R10
  AST_DIR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid |-> (dma_dir == 2'd1 || dma_dir == 2'd2)); // R3
  AST_DB_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid |-> (db_size != 2'd3) &&
                 !(db_size == DBLEN_32 && db_addr[1:0] != 2'b00) &&
                 !(db_size == DBLEN_16 && db_addr[0])); // R7
  AST_DB_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid |-> db_on); // R5
endmodule

// File: tb/sim_desc_sequencer.sv
`timescale 1ns/1ps
module sim_desc_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         desc_valid = 1'b0, desc_ready;
  logic [15:0]  desc_id = '0;
  logic [7:0]   desc_seq = '0, desc_cmd = '0, desc_db_attr = '0;
  logic [63:0]  desc_src = '0, desc_dst = '0, desc_db_addr = '0;
  logic [31:0]  desc_len = '0, desc_db_data = '0;
  logic [127:0] desc_sem = '0;
  logic         sem_valid, sem_ready = 1'b1;
  logic [31:0]  sem_cmd;
  logic         dma_valid, dma_ready = 1'b1, dma_bulk;
  logic [1:0]   dma_dir;
  logic [7:0]   dma_seq;
  logic [63:0]  dma_src, dma_dst;
  logic [31:0]  dma_len;
  logic         dma_done = 1'b0, dma_fail = 1'b0;
  logic         db_valid, db_ready = 1'b1;
  logic [63:0]  db_addr;
  logic [1:0]   db_size;
  logic [31:0]  db_data;
  logic         rsp_valid, rsp_ready = 1'b1;
  logic [15:0]  rsp_id, rsp_code;
  logic         irq_force;

  desc_sequencer u0 (
    .clk(clk), .rst_n(rst_n),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_id(desc_id),
    .desc_seq(desc_seq), .desc_cmd(desc_cmd), .desc_src(desc_src),
    .desc_dst(desc_dst), .desc_len(desc_len), .desc_db_addr(desc_db_addr),
    .desc_db_attr(desc_db_attr), .desc_db_data(desc_db_data), .desc_sem(desc_sem),
    .sem_valid(sem_valid), .sem_ready(sem_ready), .sem_cmd(sem_cmd),
    .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_dir(dma_dir),
    .dma_bulk(dma_bulk), .dma_seq(dma_seq), .dma_src(dma_src), .dma_dst(dma_dst),
    .dma_len(dma_len), .dma_done(dma_done), .dma_fail(dma_fail),
    .db_valid(db_valid), .db_ready(db_ready), .db_addr(db_addr),
    .db_size(db_size), .db_data(db_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id),
    .rsp_code(rsp_code), .irq_force(irq_force)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int ev_n = 0;
  int ev_kind [0:31];
  int ev_cyc  [0:31];
  logic [63:0] ev_data [0:31];
  logic accepted = 1'b0;
  int pend = 0;

  localparam int K_SEM = 1, K_DMA = 2, K_DB = 3, K_RSP = 4, K_IRQ = 5;

  task automatic push(input int k, input logic [63:0] d);
    if (ev_n < 32) begin
      ev_kind[ev_n] = k; ev_data[ev_n] = d; ev_cyc[ev_n] = cyc;
      ev_n++;
    end
  endtask

  // monitor and transfer-completion model, sampled at the falling edge
  initial forever begin
    @(negedge clk);
    cyc++;
    if (dma_done) dma_done = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) dma_done = 1'b1;
    end
    if (rst_n) begin
      if (desc_valid && desc_ready) accepted = 1'b1;
      if (sem_valid && sem_ready) push(K_SEM, {32'd0, sem_cmd});
      if (dma_valid && dma_ready) begin
        push(K_DMA, {21'd0, dma_dir, dma_bulk, dma_seq, dma_len});
        pend = 2;
      end
      if (db_valid && db_ready) push(K_DB, {14'd0, db_size, db_addr[15:0], db_data});
      if (rsp_valid && rsp_ready) push(K_RSP, {32'd0, rsp_id, rsp_code});
      if (irq_force) push(K_IRQ, 64'd0);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_ev(input string req, input int i, input int k, input logic [63:0] d);
    if (i >= ev_n) chk(req, 64'hFFFF_FFFF, 64'(i));
    else begin
      chk(req, 64'(ev_kind[i]), 64'(k));
      chk(req, ev_data[i], d);
    end
  endtask

  task automatic load(input logic [15:0] id, input logic [7:0] seq, input logic [7:0] cmd,
                      input logic [31:0] len, input logic [63:0] dba, input logic [7:0] attr,
                      input logic [31:0] dbd, input logic [127:0] sem);
    desc_id = id; desc_seq = seq; desc_cmd = cmd; desc_len = len;
    desc_src = 64'h1111_0000; desc_dst = 64'h2222_0000;
    desc_db_addr = dba; desc_db_attr = attr; desc_db_data = dbd; desc_sem = sem;
  endtask

  task automatic offer();
    ev_n = 0; accepted = 1'b0;
    desc_valid = 1'b1;
    for (int i = 0; i < 50 && !accepted; i++) step();
    desc_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && !desc_ready; i++) step();
    step(); step(); step();
  endtask

  task automatic run(input logic [15:0] id, input logic [7:0] seq, input logic [7:0] cmd,
                     input logic [31:0] len, input logic [63:0] dba, input logic [7:0] attr,
                     input logic [31:0] dbd, input logic [127:0] sem);
    load(id, seq, cmd, len, dba, attr, dbd, sem);
    offer();
    wait_idle();
  endtask

  task automatic t_reset();
    chk("R11 desc_ready", 64'(desc_ready), 64'd1);
    chk("R11 valids", 64'({sem_valid, dma_valid, db_valid, rsp_valid}), 64'd0);
  endtask

  task automatic t_full_order();
    run(16'h0A01, 8'h5A, 8'h19, 32'h100, 64'h1000, 8'h80, 32'hDEAD_BEEF,
        {32'h8300_0002, 32'h0300_0001, 32'h8440_0001, 32'h8200_0007});
    chk("R2 event count", 64'(ev_n), 64'd6);
    chk_ev("R4 presync first", 0, K_SEM, 64'h8440_0001);
    chk_ev("R3 R1 dma to device bulk seq", 1, K_DMA, {21'd0, 2'd1, 1'b1, 8'h5A, 32'h100});
    chk_ev("R4 postsync index 0", 2, K_SEM, 64'h8200_0007);
    chk_ev("R4 postsync index 3", 3, K_SEM, 64'h8300_0002);
    chk_ev("R5 doorbell 32-bit", 4, K_DB, {14'd0, 2'd0, 16'h1000, 32'hDEAD_BEEF});
    chk_ev("R6 response ok", 5, K_RSP, {32'd0, 16'h0A01, 16'd0});
  endtask

  task automatic t_from_dev_16();
    run(16'h0B02, 8'h33, 8'h02, 32'h40, 64'h1002, 8'h81, 32'h1234_5678, 128'd0);
    chk("R6 no response count", 64'(ev_n), 64'd2);
    chk_ev("R3 dma from device list", 0, K_DMA, {21'd0, 2'd2, 1'b0, 8'h33, 32'h40});
    chk_ev("R5 doorbell 16-bit", 1, K_DB, {14'd0, 2'd1, 16'h1002, 32'h0000_5678});
  endtask

  task automatic t_no_xfer_8();
    run(16'h0C03, 8'h00, 8'h10, 32'h0, 64'h1003, 8'h82, 32'hAABB_CCDD, 128'd0);
    chk("R3 no dma count", 64'(ev_n), 64'd2);
    chk_ev("R5 doorbell 8-bit", 0, K_DB, {14'd0, 2'd2, 16'h1003, 32'h0000_00DD});
    chk_ev("R6 response", 1, K_RSP, {32'd0, 16'h0C03, 16'd0});
  endtask

  task automatic t_errors();
    run(16'h0D01, 8'h00, 8'h13, 32'h8, 64'h1002, 8'h80, 32'h0,
        {96'd0, 32'h8200_0001});
    chk("R7 bad type count", 64'(ev_n), 64'd1);
    chk_ev("R7 bad type code 1", 0, K_RSP, {32'd0, 16'h0D01, 16'd1});
    run(16'h0D02, 8'h00, 8'h11, 32'h8, 64'h0, 8'h00, 32'h0,
        {64'd0, 32'h8540_0002, 32'h8440_0001});
    chk("R7 two presync count", 64'(ev_n), 64'd1);
    chk_ev("R7 two presync code 2", 0, K_RSP, {32'd0, 16'h0D02, 16'd2});
    run(16'h0D03, 8'h00, 8'h11, 32'h8, 64'h0, 8'h83, 32'h0, 128'd0);
    chk("R7 reserved length count", 64'(ev_n), 64'd1);
    chk_ev("R7 reserved length code 3", 0, K_RSP, {32'd0, 16'h0D03, 16'd3});
    run(16'h0D04, 8'h00, 8'h11, 32'h8, 64'h1002, 8'h80, 32'h0, 128'd0);
    chk("R7 misaligned count", 64'(ev_n), 64'd1);
    chk_ev("R7 misaligned code 4", 0, K_RSP, {32'd0, 16'h0D04, 16'd4});
    run(16'h0D05, 8'h00, 8'h10, 32'h0, 64'h1001, 8'h03, 32'h0, 128'd0);
    chk("R5 disabled doorbell unchecked count", 64'(ev_n), 64'd1);
    chk_ev("R5 disabled doorbell code 0", 0, K_RSP, {32'd0, 16'h0D05, 16'd0});
  endtask

  task automatic t_dma_fail();
    dma_fail = 1'b1;
    run(16'h0E01, 8'h07, 8'h11, 32'h20, 64'h0, 8'h80, 32'h5,
        {96'd0, 32'h8200_0001});
    dma_fail = 1'b0;
    chk("R8 fail count", 64'(ev_n), 64'd2);
    chk_ev("R8 dma issued", 0, K_DMA, {21'd0, 2'd1, 1'b0, 8'h07, 32'h20});
    chk_ev("R8 code 5", 1, K_RSP, {32'd0, 16'h0E01, 16'd5});
  endtask

  task automatic t_irq();
    run(16'h0F01, 8'h00, 8'h90, 32'h0, 64'h0, 8'h00, 32'h0, 128'd0);
    chk("R9 irq with rsp count", 64'(ev_n), 64'd2);
    chk_ev("R9 response", 0, K_RSP, {32'd0, 16'h0F01, 16'd0});
    chk_ev("R9 irq", 1, K_IRQ, 64'd0);
    if (ev_n >= 2) chk("R9 same cycle", 64'(ev_cyc[1]), 64'(ev_cyc[0]));
    run(16'h0F02, 8'h00, 8'h80, 32'h0, 64'h0, 8'h00, 32'h0, 128'd0);
    chk("R9 irq only count", 64'(ev_n), 64'd1);
    chk_ev("R9 irq without response", 0, K_IRQ, 64'd0);
  endtask

  task automatic t_backpressure();
    rsp_ready = 1'b0;
    load(16'h1234, 8'h00, 8'h10, 32'h0, 64'h0, 8'h00, 32'h0, 128'd0);
    offer();
    desc_valid = 1'b1;
    for (int i = 0; i < 8; i++) step();
    chk("R10 rsp held", 64'(rsp_valid), 64'd1);
    chk("R10 rsp id stable", 64'(rsp_id), 64'h1234);
    chk("R1 no accept while busy", 64'(desc_ready), 64'd0);
    desc_valid = 1'b0;
    for (int i = 0; i < 4; i++) step();
    chk("R10 rsp still held", 64'({rsp_valid, rsp_code}), 64'h1_0000);
    rsp_ready = 1'b1;
    wait_idle();
    chk("R10 single response", 64'(ev_n), 64'd1);
    chk_ev("R10 response delivered", 0, K_RSP, {32'd0, 16'h1234, 16'd0});
  endtask

  task automatic t_sem_stall();
    sem_ready = 1'b0;
    load(16'h2001, 8'h00, 8'h10, 32'h0, 64'h0, 8'h00, 32'h0, {96'd0, 32'h8440_0009});
    offer();
    for (int i = 0; i < 6; i++) step();
    chk("R10 sem held", 64'({sem_valid, sem_cmd}), {31'd0, 1'b1, 32'h8440_0009});
    chk("R2 waiting on presync", 64'({dma_valid, rsp_valid}), 64'd0);
    sem_ready = 1'b1;
    wait_idle();
    chk("R4 presync then response", 64'(ev_n), 64'd2);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_full_order();
    t_from_dev_16();
    t_no_xfer_8();
    t_errors();
    t_dma_fail();
    t_irq();
    t_backpressure();
    t_sem_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule